// File: doc/BRIEF.md
# Fixed-Point Format Converter

This block converts a fixed-point number from one integer/fractional split to another. It is purely combinational. Elaboration-time parameters set both formats, and each side can independently be signed or unsigned. The integer width of a signed format includes its sign bit. The word length is always the integer width plus the fractional width. The integer width may be zero or negative, which suits very small magnitudes. The fractional width must be non-negative.

The input is first aligned to the output's fractional width. Extra low bits are discarded, which rounds toward minus infinity. Missing low bits are filled with zeros. The aligned value is then fitted to the output range in one of two ways, chosen by a parameter:

- **Wrap:** the upper bits are simply dropped.
- **Saturate:** an out-of-range value is clamped to the nearest representable limit, and the clip flag is raised.

Signed-to-unsigned and unsigned-to-signed conversions are handled the same way. The block sits inline in datapaths, between stages that use different word lengths.

Top module: `fp_format_conv`

## Requirements
- R1: The input word length is IN_IW+IN_QW and the output word length is OUT_IW+OUT_QW. A negative integer width is accepted as long as the resulting word length is at least 1.
- R2: When OUT_QW < IN_QW, the dropped fractional bits are discarded, giving floor toward minus infinity. For example, signed -0.03125 converted to 3 fractional bits gives -0.125.
- R3: When OUT_QW > IN_QW, the output carries OUT_QW-IN_QW zero bits below the input's least significant bit.
- R4: When the integer width grows, a signed input is sign-extended and an unsigned input is zero-padded, and clip_o stays low.
- R5: In wrap mode (SATURATE=0), the output is the low OUT_WL bits of the aligned value, and clip_o is always 0.
- R6: In saturate mode, an aligned value above the output maximum gives that maximum, and one below the output minimum gives that minimum. In both cases clip_o is 1. A signed maximum is 0 followed by all ones, and a signed minimum is 1 followed by all zeros. An unsigned maximum is all ones, and an unsigned minimum is 0.
- R7: In saturating signed-to-unsigned conversion, every negative input produces 0 with clip_o=1.
- R8: In saturating unsigned-to-signed conversion, the input is treated as non-negative. A value above the signed maximum produces that maximum with clip_o=1, and the output sign bit is never set.
- R9: In saturate mode, clip_o is 0 whenever the aligned value lies within the output range, and the output then equals that value exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_i | input | IN_IW+IN_QW | Input fixed-point value |
| out_o | output | OUT_IW+OUT_QW | Converted fixed-point value |
| clip_o | output | 1 | High when saturation changed the value |

## Verification
The block holds no state, so any fault in alignment, range detection or limit selection shows on out_o or clip_o in the same cycle as the input that exercises it. A wrong shift direction shows up as scaled outputs across the whole input range. A misplaced range limit shows up only at values next to the output minimum or maximum. For this reason every configuration is swept over its complete input space. The configurations cover a shrinking integer part, a negative integer width, sign changes, and both fitting modes.

// File: rtl/fp_conv_pkg.sv
package fp_conv_pkg;
  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // working width: holds the aligned input and any output limit, plus sign headroom
  function automatic int work_width(input int in_wl, input int in_qw,
                                    input int out_wl, input int out_qw);
    return max_i(in_wl + max_i(out_qw - in_qw, 0), out_wl) + 2;
  endfunction
endpackage

// File: rtl/fp_conv_align.sv
module fp_conv_align #(
  parameter int IN_WL     = 8,
  parameter bit IN_SIGNED = 1'b1,
  parameter int W         = 12,
  parameter int SHL       = 0,
  parameter int SHR       = 0
) (
  input  logic [IN_WL-1:0]    in_i,
  output logic signed [W-1:0] aligned_o
);
  logic signed [W-1:0] ext;

  generate
    if (IN_SIGNED) begin : g_sext
      assign ext = {{(W-IN_WL){in_i[IN_WL-1]}}, in_i};
    end else begin : g_zext
      assign ext = {{(W-IN_WL){1'b0}}, in_i};
    end
  endgenerate

  // arithmetic right shift floors toward minus infinity
  assign aligned_o = (ext <<< SHL) >>> SHR;
endmodule

// File: rtl/fp_conv_range.sv
module fp_conv_range #(
  parameter int W          = 12,
  parameter int OUT_WL     = 8,
  parameter bit OUT_SIGNED = 1'b1
) (
  input  logic signed [W-1:0] val_i,
  output logic signed [W-1:0] hi_o,
  output logic signed [W-1:0] lo_o,
  output logic                over_o,
  output logic                under_o
);
  localparam int HI_SH = OUT_SIGNED ? OUT_WL - 1 : OUT_WL;

  logic signed [W-1:0] one_w;
  assign one_w = W'(1);

  assign hi_o = (one_w <<< HI_SH) - one_w;

  generate
    if (OUT_SIGNED) begin : g_slo
      assign lo_o = -(one_w <<< (OUT_WL - 1));
    end else begin : g_ulo
      assign lo_o = '0;
    end
  endgenerate

  assign over_o  = val_i > hi_o;
  assign under_o = val_i < lo_o;
endmodule

// File: rtl/fp_conv_fit.sv
module fp_conv_fit #(
  parameter int W        = 12,
  parameter int OUT_WL   = 8,
  parameter bit SATURATE = 1'b1
) (
  input  logic signed [W-1:0] val_i,
  input  logic signed [W-1:0] hi_i,
  input  logic signed [W-1:0] lo_i,
  input  logic                over_i,
  input  logic                under_i,
  output logic [OUT_WL-1:0]   out_o,
  output logic                clip_o
);
  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        if (over_i)       out_o = hi_i[OUT_WL-1:0];
        else if (under_i) out_o = lo_i[OUT_WL-1:0];
        else              out_o = val_i[OUT_WL-1:0];
      end
      assign clip_o = over_i | under_i;
    end else begin : g_wrap
      assign out_o  = val_i[OUT_WL-1:0];
      assign clip_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fp_format_conv.sv
module fp_format_conv
  import fp_conv_pkg::*;
#(
  parameter int IN_IW      = 4,
  parameter int IN_QW      = 4,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_IW     = 2,
  parameter int OUT_QW     = 6,
  parameter bit OUT_SIGNED = 1'b1,
  parameter bit SATURATE   = 1'b1,
  localparam int IN_WL     = IN_IW + IN_QW,
  localparam int OUT_WL    = OUT_IW + OUT_QW
) (
  input  logic [IN_WL-1:0]  in_i,
  output logic [OUT_WL-1:0] out_o,
  output logic              clip_o
);
  localparam int SHL = max_i(OUT_QW - IN_QW, 0);
  localparam int SHR = max_i(IN_QW - OUT_QW, 0);
  localparam int W   = work_width(IN_WL, IN_QW, OUT_WL, OUT_QW);

  logic signed [W-1:0] aligned, hi, lo;
  logic                over, under;

  fp_conv_align #(
    .IN_WL(IN_WL), .IN_SIGNED(IN_SIGNED), .W(W), .SHL(SHL), .SHR(SHR)
  ) u_align (
    .in_i(in_i), .aligned_o(aligned)
  );

  fp_conv_range #(
    .W(W), .OUT_WL(OUT_WL), .OUT_SIGNED(OUT_SIGNED)
  ) u_range (
    .val_i(aligned), .hi_o(hi), .lo_o(lo), .over_o(over), .under_o(under)
  );

  fp_conv_fit #(
    .W(W), .OUT_WL(OUT_WL), .SATURATE(SATURATE)
  ) u_fit (
    .val_i(aligned), .hi_i(hi), .lo_i(lo), .over_i(over), .under_i(under),
    .out_o(out_o), .clip_o(clip_o)
  );
endmodule

// File: rtl/fp_format_conv_chk.sv
module fp_format_conv_chk #(
  parameter int IN_IW      = 4,
  parameter int IN_QW      = 4,
  parameter bit IN_SIGNED  = 1'b1,
  parameter int OUT_IW     = 2,
  parameter int OUT_QW     = 6,
  parameter bit OUT_SIGNED = 1'b1,
  parameter bit SATURATE   = 1'b1,
  localparam int IN_WL     = IN_IW + IN_QW,
  localparam int OUT_WL    = OUT_IW + OUT_QW
) (
  input logic [IN_WL-1:0]  in_i,
  input logic [OUT_WL-1:0] out_o,
  input logic              clip_o
);
  logic [OUT_WL-1:0] ones, hi_pat, lo_pat;
  assign ones   = '1;
  assign hi_pat = OUT_SIGNED ? (ones >> 1) : ones;
  assign lo_pat = OUT_SIGNED ? ~(ones >> 1) : '0;

  generate
    if (!SATURATE) begin : g_wrap_chk
      always_comb begin
        a_r5_wrap_clip_low: assert (!clip_o)
          else $error("R5: clip raised in wrap mode");
      end
    end else begin : g_sat_chk
      always_comb begin
        if (clip_o) begin
          a_r6_clip_at_limit: assert (out_o == hi_pat || out_o == lo_pat)
            else $error("R6: clipped output not at a range limit");
        end
      end
    end

    if (SATURATE && IN_SIGNED && !OUT_SIGNED) begin : g_s2u_chk
      always_comb begin
        if (in_i[IN_WL-1]) begin
          a_r7_neg_to_zero: assert (out_o == '0 && clip_o)
            else $error("R7: negative input not clipped to zero");
        end
      end
    end

    if (SATURATE && !IN_SIGNED && OUT_SIGNED) begin : g_u2s_chk
      always_comb begin
        a_r8_u2s_nonneg: assert (!out_o[OUT_WL-1])
          else $error("R8: unsigned input produced negative output");
      end
    end

    if (IN_QW == OUT_QW && OUT_WL >= IN_WL && IN_SIGNED == OUT_SIGNED) begin : g_widen_chk
      always_comb begin
        a_r4_widen_keeps_bits: assert (out_o[IN_WL-1:0] == in_i && !clip_o)
          else $error("R4: widening altered the value");
      end
    end
  endgenerate
endmodule

bind fp_format_conv fp_format_conv_chk #(
  .IN_IW(IN_IW), .IN_QW(IN_QW), .IN_SIGNED(IN_SIGNED),
  .OUT_IW(OUT_IW), .OUT_QW(OUT_QW), .OUT_SIGNED(OUT_SIGNED), .SATURATE(SATURATE)
) u_chk (
  .in_i(in_i), .out_o(out_o), .clip_o(clip_o)
);

// File: tb/tb_fp_format_conv.sv
module tb_fp_format_conv;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] stim = '0;

  // c0: s4.4 -> s2.6 saturate
  logic [7:0]  o0; logic c0;
  // c1: s4.4 -> s2.6 wrap
  logic [7:0]  o1; logic c1;
  // c2: s3.5 -> u2.3 saturate
  logic [4:0]  o2; logic c2;
  // c3: u4.4 -> s3.4 saturate
  logic [6:0]  o3; logic c3;
  // c4: s-2.10 -> s1.12 wrap
  logic [12:0] o4; logic c4;
  // c5: u2.2 -> u4.2 wrap
  logic [5:0]  o5; logic c5;

  fp_format_conv dut (.in_i(stim), .out_o(o0), .clip_o(c0));
  fp_format_conv #(.SATURATE(1'b0)) dut_wrap (.in_i(stim), .out_o(o1), .clip_o(c1));
  fp_format_conv #(.IN_IW(3), .IN_QW(5), .IN_SIGNED(1'b1), .OUT_IW(2), .OUT_QW(3),
                   .OUT_SIGNED(1'b0), .SATURATE(1'b1))
    dut_s2u (.in_i(stim), .out_o(o2), .clip_o(c2));
  fp_format_conv #(.IN_IW(4), .IN_QW(4), .IN_SIGNED(1'b0), .OUT_IW(3), .OUT_QW(4),
                   .OUT_SIGNED(1'b1), .SATURATE(1'b1))
    dut_u2s (.in_i(stim), .out_o(o3), .clip_o(c3));
  fp_format_conv #(.IN_IW(-2), .IN_QW(10), .IN_SIGNED(1'b1), .OUT_IW(1), .OUT_QW(12),
                   .OUT_SIGNED(1'b1), .SATURATE(1'b0))
    dut_neg (.in_i(stim), .out_o(o4), .clip_o(c4));
  fp_format_conv #(.IN_IW(2), .IN_QW(2), .IN_SIGNED(1'b0), .OUT_IW(4), .OUT_QW(2),
                   .OUT_SIGNED(1'b0), .SATURATE(1'b0))
    dut_uz (.in_i(stim[3:0]), .out_o(o5), .clip_o(c5));

  // behavioural reference: scale, then clamp or wrap
  function automatic void model(input longint x, input int iq, input int ow, input int oq,
                                input bit os, input bit sat,
                                output longint y, output bit c);
    longint v, hi, lo, mask;
    if (oq >= iq) v = x * (longint'(1) << (oq - iq));
    else          v = x >>> (iq - oq);
    hi = os ? (longint'(1) << (ow - 1)) - 1 : (longint'(1) << ow) - 1;
    lo = os ? -(longint'(1) << (ow - 1)) : 0;
    mask = (longint'(1) << ow) - 1;
    c = 1'b0;
    if (sat && v > hi) begin v = hi; c = 1'b1; end
    else if (sat && v < lo) begin v = lo; c = 1'b1; end
    y = v & mask;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp,
                       input bit gotc, input bit expc);
    n_checks++;
    if (got !== exp || gotc !== expc) begin
      n_fail++;
      $display("FAIL %s stim=%0h: out=%0h clip=%0b expected out=%0h clip=%0b",
               tag, stim, got, gotc, exp, expc);
    end
  endtask

  task automatic check_all();
    longint y; bit c;
    model(longint'($signed(stim)), 4, 8, 6, 1'b1, 1'b1, y, c);
    check("R6/R9/R3 s4.4->s2.6 sat", longint'(o0), y, c0, c);
    model(longint'($signed(stim)), 4, 8, 6, 1'b1, 1'b0, y, c);
    check("R5 s4.4->s2.6 wrap", longint'(o1), y, c1, c);
    model(longint'($signed(stim)), 5, 5, 3, 1'b0, 1'b1, y, c);
    check("R7/R2 s3.5->u2.3 sat", longint'(o2), y, c2, c);
    model(longint'(stim), 4, 7, 4, 1'b1, 1'b1, y, c);
    check("R8 u4.4->s3.4 sat", longint'(o3), y, c3, c);
    model(longint'($signed(stim)), 10, 13, 12, 1'b1, 1'b0, y, c);
    check("R1/R4 s-2.10->s1.12", longint'(o4), y, c4, c);
    model(longint'(stim[3:0]), 2, 6, 2, 1'b0, 1'b0, y, c);
    check("R4 u2.2->u4.2 zero pad", longint'(o5), y, c5, c);
  endtask

  initial begin
    #200000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: timed out, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    stim = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero input gives zero output, no clip (R9)
    check("R9 reset zero s2.6", longint'(o0), 0, c0, 1'b0);
    check("R9 reset zero u2.3", longint'(o2), 0, c2, 1'b0);
    rst_ni = 1'b1;
    // directed corners
    @(posedge clk); #1 stim = 8'h7f;   // +7.9375 -> s2.6 max 0x7f, clip
    @(negedge clk);
    check("R6 positive clamp", longint'(o0), 64'h7f, c0, 1'b1);
    @(posedge clk); #1 stim = 8'h80;   // -8.0 -> s2.6 min 0x80, clip
    @(negedge clk);
    check("R6 negative clamp", longint'(o0), 64'h80, c0, 1'b1);
    check("R7 negative to zero", longint'(o2), 0, c2, 1'b1);
    @(posedge clk); #1 stim = 8'hff;   // s3.5 -1/32 floors; s-2.10 sign extends
    @(negedge clk);
    check("R2 floor of -1/32", longint'(o2), 0, c2, 1'b1);
    check("R4 sign extension", longint'(o4), 64'h1ffc, c4, 1'b0);
    check("R8 unsigned max clamp", longint'(o3), 64'h3f, c3, 1'b1);
    @(posedge clk); #1 stim = 8'h05;   // s4.4 0.3125 -> s2.6 0x14
    @(negedge clk);
    check("R3 zero append", longint'(o0), 64'h14, c0, 1'b0);
    // exhaustive sweep on every clock
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #1 stim = 8'(i);
      @(negedge clk);
      check_all();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule